// File: doc/BRIEF.md
# Buffered Serial Character Transmitter

This block turns parallel characters into an asynchronous serial stream on one line. It works from a clock that runs at sixteen times the bit rate. A host writes a character into a holding buffer through an active-low load strobe. The rising edge of that strobe passes the character on to the serial shifter. If the shifter is still sending, the character waits in the buffer, so two characters leave the block back to back with no idle gap between them.

The format is taken from five static inputs at the moment a character moves from the buffer into the shifter, and the character keeps that format for its whole frame. The inputs set the character length (5 to 8 bits), whether a parity bit is sent, odd or even parity, and a long stop option. Two flags tell the host what it may do next. `hold_empty` high means the buffer can accept a new character. `shift_empty` high means the line is idle and the last frame, including its stop bits, has been sent in full.

Top module: `async_char_tx`

## Requirements
- R1: While `rst` is high, `ser_out` is 1, `hold_empty` is 1 and `shift_empty` is 0. After `rst` falls, `shift_empty` goes high within 18 clocks (16 clocks with the default setting).
- R2: On every clock with `load_n` low, the buffer takes `data_in`. The character sent is the `data_in` value from the last clock at which `load_n` was low.
- R3: If `hold_empty` is high and the clock samples `load_n` high after it was low, `hold_empty` is low one clock later.
- R4: If the shifter is idle, the character moves in on the next clock. In that cycle `hold_empty` returns to 1, `shift_empty` goes to 0 and `ser_out` drops to 0 for the start bit.
- R5: If a character is still being sent when a load edge arrives, the new character stays in the buffer with `hold_empty` low until the last stop clock of the current frame. Its start bit then begins on the very next clock, and `shift_empty` stays low throughout.
- R6: A frame is sent in this order: a low start bit, then the data bits with the least significant bit first. `len_code` sets the data length: 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Any `data_in` bits above the chosen length have no effect on the line.
- R7: With `par_off` high, no parity bit is sent. Otherwise one parity bit follows the data. It is computed over the chosen data bits only, so that the total count of ones is even when `par_even` is 1 and odd when `par_even` is 0.
- R8: Each start, data and parity bit lasts 16 clocks. The stop period is high and lasts 16 clocks when `stop_long` is 0. When `stop_long` is 1 it lasts 24 clocks for 5-bit characters and 32 clocks for longer ones.
- R9: `shift_empty` rises on the clock that follows the last stop clock, when no character is waiting. While `shift_empty` is high, `ser_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_x16 | input | 1 | Transmit clock, 16 times the bit rate |
| rst | input | 1 | Synchronous master reset, active high |
| load_n | input | 1 | Buffer load strobe; captures while low, hands off on rising edge |
| data_in | input | 8 | Parallel character, right-justified |
| len_code | input | 2 | Character length: 5 + code bits |
| par_off | input | 1 | 1 disables the parity bit |
| par_even | input | 1 | 1 selects even parity, 0 odd |
| stop_long | input | 1 | 1 selects 1.5 (5-bit) or 2 stop bits |
| ser_out | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding buffer can accept a character |
| shift_empty | output | 1 | No frame in progress and none pending |

## Verification
The bench sends every character length, both parity senses, parity off, and both stop options. It includes the 1.5-stop case, where a design that counted 16 or 32 clocks would raise `shift_empty` at the wrong point in the frame. Characters with their unused upper bits set catch a design that leaks those bits into the data or the parity. A load made in the middle of a frame checks that the second start bit follows the last stop clock directly. A design that waited for idle would let `shift_empty` pulse high, and a design that transferred early would cut the first frame short. A strobe held low while the data changes checks that the last value captured is the one sent. A reset in the middle of a frame, followed by the warm-up limit, checks that the line goes back to idle and that the empty flag comes back in time.

// File: rtl/txser_pkg.sv
package txser_pkg;

   typedef enum logic [1:0] {
      TX_WARM = 2'd0,
      TX_IDLE = 2'd1,
      TX_SEND = 2'd2
   } tx_state_e;

   typedef struct packed {
      logic [1:0] len_code;
      logic       par_off;
      logic       par_even;
      logic       stop_long;
   } tx_fmt_t;

   localparam int MIN_CHAR_BITS = 5;

endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_n,
   input  logic [DATA_W-1:0] data_in,
   input  logic              take,
   output logic [DATA_W-1:0] hold_q,
   output logic              full_q
);

   logic load_n_q;
   logic load_rise;

   // edge detector tracks the strobe even in reset
   always_ff @(posedge clk) begin
      load_n_q <= load_n;
   end

   assign load_rise = load_n & ~load_n_q;

   // buffer is transparent to data_in while the strobe is low
   always_ff @(posedge clk) begin
      if (!load_n) begin
         hold_q <= data_in;
      end
   end

   // a take wins: the taken character is already the newest one
   always_ff @(posedge clk) begin
      if (rst) begin
         full_q <= 1'b0;
      end else if (take) begin
         full_q <= 1'b0;
      end else if (load_rise) begin
         full_q <= 1'b1;
      end
   end

endmodule

// File: rtl/tx_frame_build.sv
module tx_frame_build
   import txser_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OS     = 16,
   parameter int FW     = DATA_W + 3,
   parameter int CW     = 8
) (
   input  logic [DATA_W-1:0] data,
   input  tx_fmt_t           fmt,
   output logic [FW-1:0]     frame,
   output logic [CW-1:0]     clocks
);

   logic [DATA_W-1:0] keep;
   int                n_bits;

   assign n_bits = int'(fmt.len_code) + MIN_CHAR_BITS;

   // per-bit mask of the programmed character length
   for (genvar g = 0; g < DATA_W; g++) begin : g_keep
      assign keep[g] = (g < n_bits);
   end

   always_comb begin
      logic par;
      int   stop_clks;
      int   total;
      par   = 1'b0;
      frame = '1;
      for (int i = 0; i < DATA_W; i++) begin
         if (keep[i]) begin
            frame[i] = data[i];
            par      = par ^ data[i];
         end
      end
      for (int i = 0; i < FW; i++) begin
         if (i == n_bits && !fmt.par_off) begin
            frame[i] = fmt.par_even ? par : ~par;
         end
      end
      if (!fmt.stop_long) begin
         stop_clks = OS;
      end else if (n_bits == MIN_CHAR_BITS) begin
         stop_clks = (OS * 3) / 2;
      end else begin
         stop_clks = 2 * OS;
      end
      total  = OS * (1 + n_bits + (fmt.par_off ? 0 : 1)) + stop_clks;
      clocks = CW'(total);
   end

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
   import txser_pkg::*;
#(
   parameter int OS        = 16,
   parameter int FW        = 11,
   parameter int CW        = 8,
   parameter int WARM_CLKS = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          full,
   input  logic [FW-1:0] frame_in,
   input  logic [CW-1:0] clocks_in,
   output logic          take,
   output logic          ser_out,
   output logic          shift_empty
);

   localparam int SW = (OS > 1) ? $clog2(OS) : 1;
   localparam int WW = $clog2(WARM_CLKS + 1);

   tx_state_e     state;
   logic [SW-1:0] sub_q;
   logic [CW-1:0] rem_q;
   logic [FW-1:0] sh_q;
   logic [WW-1:0] warm_q;
   logic          last_clk;

   assign last_clk = (state == TX_SEND) && (rem_q == '0);
   assign take     = full && ((state == TX_IDLE) || last_clk);

   always_ff @(posedge clk) begin
      if (rst) begin
         state       <= TX_WARM;
         warm_q      <= '0;
         sub_q       <= '0;
         rem_q       <= '0;
         sh_q        <= '1;
         ser_out     <= 1'b1;
         shift_empty <= 1'b0;
      end else if (state == TX_WARM) begin
         warm_q <= warm_q + WW'(1);
         if (warm_q == WW'(WARM_CLKS - 1)) begin
            state       <= TX_IDLE;
            shift_empty <= 1'b1;
         end
      end else if (take) begin
         state       <= TX_SEND;
         ser_out     <= 1'b0;
         sh_q        <= frame_in;
         rem_q       <= clocks_in - CW'(1);
         sub_q       <= '0;
         shift_empty <= 1'b0;
      end else if (state == TX_SEND) begin
         if (last_clk) begin
            state       <= TX_IDLE;
            ser_out     <= 1'b1;
            shift_empty <= 1'b1;
         end else begin
            rem_q <= rem_q - CW'(1);
            if (sub_q == SW'(OS - 1)) begin
               sub_q   <= '0;
               ser_out <= sh_q[0];
               sh_q    <= {1'b1, sh_q[FW-1:1]};
            end else begin
               sub_q <= sub_q + SW'(1);
            end
         end
      end
   end

endmodule

// File: rtl/async_char_tx.sv
module async_char_tx
   import txser_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16,
   parameter int WARM_CLKS  = 16
) (
   input  logic              clk_x16,
   input  logic              rst,
   input  logic              load_n,
   input  logic [DATA_W-1:0] data_in,
   input  logic [1:0]        len_code,
   input  logic              par_off,
   input  logic              par_even,
   input  logic              stop_long,
   output logic              ser_out,
   output logic              hold_empty,
   output logic              shift_empty
);

   localparam int FW      = DATA_W + 3;
   localparam int MAX_CLK = OVERSAMPLE * (DATA_W + 2) + 2 * OVERSAMPLE;
   localparam int CW      = $clog2(MAX_CLK + 1);

   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must cover an 8-bit character");
   end
   if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
      $error("OVERSAMPLE must be even and at least 4");
   end
   if (WARM_CLKS < 1 || WARM_CLKS > 18) begin : g_bad_warm
      $error("WARM_CLKS must lie in 1..18");
   end

   logic [DATA_W-1:0] hold_q;
   logic              full_q;
   logic              take;
   logic [FW-1:0]     frame;
   logic [CW-1:0]     clocks;
   tx_fmt_t           fmt;

   assign fmt        = '{len_code: len_code, par_off: par_off,
                         par_even: par_even, stop_long: stop_long};
   assign hold_empty = ~full_q;

   tx_hold_buf #(.DATA_W(DATA_W)) u_buf (
      .clk     (clk_x16),
      .rst     (rst),
      .load_n  (load_n),
      .data_in (data_in),
      .take    (take),
      .hold_q  (hold_q),
      .full_q  (full_q)
   );

   tx_frame_build #(.DATA_W(DATA_W), .OS(OVERSAMPLE), .FW(FW), .CW(CW)) u_build (
      .data   (hold_q),
      .fmt    (fmt),
      .frame  (frame),
      .clocks (clocks)
   );

   tx_shifter #(.OS(OVERSAMPLE), .FW(FW), .CW(CW), .WARM_CLKS(WARM_CLKS)) u_shift (
      .clk         (clk_x16),
      .rst         (rst),
      .full        (full_q),
      .frame_in    (frame),
      .clocks_in   (clocks),
      .take        (take),
      .ser_out     (ser_out),
      .shift_empty (shift_empty)
   );

endmodule

// File: rtl/async_char_tx_chk.sv
module async_char_tx_chk (
   input logic clk_x16,
   input logic rst,
   input logic load_n,
   input logic ser_out,
   input logic hold_empty,
   input logic shift_empty
);

   logic [4:0] since_rst;
   logic       load_seen;

   always_ff @(posedge clk_x16) begin
      if (rst) begin
         since_rst <= '0;
         load_seen <= 1'b0;
      end else begin
         if (since_rst != 5'd31) since_rst <= since_rst + 5'd1;
         if (!load_n) load_seen <= 1'b1;
      end
   end

   // R1
   warm_up_limit_chk: assert property (@(posedge clk_x16) disable iff (rst)
      (since_rst == 5'd18 && !load_seen) |-> shift_empty);

   // R3
   load_edge_flag_chk: assert property (@(posedge clk_x16) disable iff (rst)
      ($rose(load_n) && hold_empty) |=> !hold_empty);

   // R4
   idle_handoff_chk: assert property (@(posedge clk_x16) disable iff (rst)
      (!hold_empty && shift_empty) |=> !shift_empty);

   // R4
   start_with_busy_chk: assert property (@(posedge clk_x16) disable iff (rst)
      $fell(shift_empty) |-> !ser_out);

   // R9
   idle_line_high_chk: assert property (@(posedge clk_x16) disable iff (rst)
      shift_empty |-> ser_out);

endmodule

bind async_char_tx async_char_tx_chk u_chk (
   .clk_x16     (clk_x16),
   .rst         (rst),
   .load_n      (load_n),
   .ser_out     (ser_out),
   .hold_empty  (hold_empty),
   .shift_empty (shift_empty)
);

// File: tb/async_char_tx_bench.sv
module async_char_tx_bench;

   localparam int OS   = 16;
   localparam int NVEC = 8;

   // {data[7:0], len_code[1:0], par_off, par_even, stop_long, frame_clocks[8:0]}
   localparam logic [21:0] VEC [NVEC] = '{
      {8'hA5, 2'd3, 1'b0, 1'b1, 1'b0, 9'd176},
      {8'hE3, 2'd0, 1'b0, 1'b0, 1'b1, 9'd136},
      {8'hFF, 2'd1, 1'b1, 1'b0, 1'b1, 9'd144},
      {8'h5A, 2'd2, 1'b0, 1'b1, 1'b1, 9'd176},
      {8'h00, 2'd3, 1'b0, 1'b0, 1'b0, 9'd176},
      {8'hC1, 2'd0, 1'b1, 1'b1, 1'b0, 9'd112},
      {8'h7F, 2'd2, 1'b0, 1'b0, 1'b0, 9'd160},
      {8'h3C, 2'd1, 1'b0, 1'b1, 1'b1, 9'd160}
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       load_n = 1'b1;
   logic [7:0] data_in = '0;
   logic [1:0] len_code = 2'd3;
   logic       par_off = 1'b1;
   logic       par_even = 1'b0;
   logic       stop_long = 1'b0;
   logic       ser_out, hold_empty, shift_empty;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   async_char_tx u_async_char_tx (
      .clk_x16     (clk),
      .rst         (rst),
      .load_n      (load_n),
      .data_in     (data_in),
      .len_code    (len_code),
      .par_off     (par_off),
      .par_even    (par_even),
      .stop_long   (stop_long),
      .ser_out     (ser_out),
      .hold_empty  (hold_empty),
      .shift_empty (shift_empty)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic exp_line(int k, logic [7:0] d, int n, logic poff, logic ev);
      int   b;
      logic p;
      b = k / OS;
      p = 1'b0;
      for (int j = 0; j < n; j++) p = p ^ d[j];
      if (b == 0) return 1'b0;
      if (b <= n) return d[b-1];
      if (!poff && b == n + 1) return ev ? p : ~p;
      return 1'b1;
   endfunction

   // strobe a character; returns on the start-bit cycle (k = 0) when idle
   task automatic load_idle(logic [7:0] d);
      data_in = d;
      load_n  = 1'b0;
      tick();
      load_n = 1'b1;
      tick();
      check("R3 hold_empty low after load edge", int'(hold_empty), 0);
      tick();
      check("R4 start bit", int'(ser_out), 0);
      check("R4 hold_empty back", int'(hold_empty), 1);
      check("R4 shift_empty cleared", int'(shift_empty), 0);
   endtask

   task automatic run_frame(logic [7:0] d, int n, logic poff, logic ev, int nclk,
                            bit next_pending);
      for (int k = 1; k <= nclk; k++) begin
         tick();
         if (k < nclk && (k % OS) == OS / 2)
            check("R6 R7 R8 line bit", int'(ser_out), int'(exp_line(k, d, n, poff, ev)));
         if (k == nclk - 1) begin
            check("R8 last stop clock high", int'(ser_out), 1);
            check("R9 still busy on last stop", int'(shift_empty), 0);
         end
         if (k == nclk) begin
            if (next_pending) begin
               check("R5 back-to-back start", int'(ser_out), 0);
               check("R5 shift_empty stays low", int'(shift_empty), 0);
               check("R5 buffer handed off", int'(hold_empty), 1);
            end else begin
               check("R9 shift_empty after stop", int'(shift_empty), 1);
               check("R9 idle line", int'(ser_out), 1);
            end
         end
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      int c;
      // R1 reset state and warm-up
      repeat (4) tick();
      check("R1 reset ser_out", int'(ser_out), 1);
      check("R1 reset hold_empty", int'(hold_empty), 1);
      check("R1 reset shift_empty", int'(shift_empty), 0);
      rst = 1'b0;
      c = 0;
      for (int i = 1; i <= 18; i++) begin
         tick();
         if (shift_empty && c == 0) c = i;
      end
      check("R1 warm-up within 18", int'(c >= 1 && c <= 18), 1);

      // table walk over formats
      foreach (VEC[v]) begin
         logic [7:0] d;
         d         = VEC[v][21:14];
         len_code  = VEC[v][13:12];
         par_off   = VEC[v][11];
         par_even  = VEC[v][10];
         stop_long = VEC[v][9];
         load_idle(d);
         run_frame(d, int'(len_code) + 5, par_off, par_even, int'(VEC[v][8:0]), 1'b0);
         tick();
      end

      // R2 transparent buffer: last value while strobe low is sent
      len_code = 2'd3; par_off = 1'b1; stop_long = 1'b0;
      data_in = 8'h11; load_n = 1'b0;
      tick();
      data_in = 8'h22;
      tick();
      data_in = 8'h5C;
      tick();
      load_n = 1'b1;
      data_in = 8'hFF;
      tick();
      tick();
      check("R2 start after capture", int'(ser_out), 0);
      run_frame(8'h5C, 8, 1'b1, 1'b0, 160, 1'b0);
      tick();

      // R5 second load while busy
      load_idle(8'h96);
      repeat (20) tick();
      data_in = 8'h4B; load_n = 1'b0;
      tick();
      load_n = 1'b1;
      tick();
      tick();
      check("R5 waiting character holds buffer", int'(hold_empty), 0);
      for (int k = 24; k < 160; k++) begin
         tick();
         if (k == 159) check("R5 still waiting at last stop", int'(hold_empty), 0);
      end
      tick();
      check("R5 second start follows", int'(ser_out), 0);
      check("R5 no idle gap", int'(shift_empty), 0);
      run_frame(8'h4B, 8, 1'b1, 1'b0, 160, 1'b0);
      tick();

      // R1 reset in the middle of a frame
      load_idle(8'h00);
      repeat (20) tick();
      check("R1 mid-frame data low", int'(ser_out), 0);
      rst = 1'b1;
      tick();
      tick();
      check("R1 reset forces line high", int'(ser_out), 1);
      check("R1 reset empties buffer flag", int'(hold_empty), 1);
      check("R1 reset clears shift_empty", int'(shift_empty), 0);
      rst = 1'b0;
      c = 0;
      for (int i = 1; i <= 18; i++) begin
         tick();
         if (shift_empty && c == 0) c = i;
      end
      check("R1 warm-up after mid-frame reset", int'(c >= 1 && c <= 18), 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule